// File: doc/BRIEF.md
# Hierarchical Halted-Hart Summary

This block lets a debugger find halted harts in a large population without polling every hart. It takes one halted status bit per hart and a hart-select value, and it offers four 32-bit read-only summary words through a small register read port. Level 0 shows individual harts. Each higher level folds 32 groups of the level below into one bit, so level k bit i is set when any hart in a run of 32^k consecutive harts is halted.

Below the top level, each level shows only a 32-bit window of its groups. The hart-select bits above position 5k+5 choose that window. A debugger reads the coarsest useful level, picks a set bit, writes the matching hart-select value, and reads the next lower level. It repeats this until it reaches a single hart. When the hart count is small, the upper levels are not built. They read as zero and the search starts lower down.

The read port is driven by a two-state machine. In `RD_IDLE` no response is pending. In `RD_RESP` the captured word is valid. A request in either state moves the machine to `RD_RESP`. A cycle without a request moves it to `RD_IDLE`. The summary is combinational from the halted inputs and is sampled into one output register in the request cycle.

Top module: `hsum_top`

## Requirements
- R1: While reset (active low) is asserted, `rd_valid` is 0 and `rd_data` is 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_en` high, and 0 after a cycle with `rd_en` low.
- R3: Reading address 0 (level 0) returns bit i = halted[hartsel[HARTSEL_W-1:5]*32 + i].
- R4: Reading address 1 (level 1) returns bit i = OR of halted[hartsel[HARTSEL_W-1:10]*1024 + 32*i +: 32].
- R5: Bits that map to harts at or above NUM_HARTS read as 0, including whole windows past the last hart.
- R6: A level k>0 with NUM_HARTS <= 32^k is not built, and reading it (address 2 or 3 with the default 100 harts) returns 0.
- R7: `rd_data` holds the summary as it was in the request cycle. It keeps that value unchanged through any cycle without a request, even if the halted inputs change.
- R8: The hart-select bits below position 5 have no effect on any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halted | input | NUM_HARTS | Halted status, one bit per hart |
| hartsel | input | HARTSEL_W | Hart-select value that chooses the lower-level windows |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Summary level to read (0 = finest, 3 = coarsest) |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Summary word |

## Verification
A wrong state in the read machine shows up at once as `rd_valid` out of step with the request one cycle earlier. A stale output register shows up as a word that changes without a request. A wrong group reduction or window index shows up on the first read of the affected level, as a set bit in the wrong position or a missing bit. Placing single halted harts on each side of the 32-hart and 1024-hart boundaries, and past the last hart, exposes each indexing error within one read.

// File: rtl/hsum_pkg.sv
package hsum_pkg;

    localparam int SUM_W    = 32;
    localparam int LVL_SH   = 5;
    localparam int NUM_LVLS = 4;

    typedef logic [SUM_W-1:0] sum_word_t;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int pow32(input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) r = r * SUM_W;
        return r;
    endfunction

endpackage

// File: rtl/hsum_reduce.sv
module hsum_reduce
    import hsum_pkg::*;
#(
    parameter int IN_W  = 128,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  in_bits,
    output logic [OUT_W-1:0] out_bits
);

    localparam int NGRP = IN_W / SUM_W;

    always_comb begin
        out_bits = '0;
        for (int j = 0; j < NGRP; j++) begin
            out_bits[j] = |in_bits[j*SUM_W +: SUM_W];
        end
    end

endmodule

// File: rtl/hsum_window.sv
module hsum_window
    import hsum_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SEL_W = 20,
    parameter int SHIFT = 5
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [SEL_W-1:0] sel,
    output sum_word_t        win
);

    localparam int NWIN = VEC_W / SUM_W;

    logic [SEL_W-1:0] idx;

    assign idx = sel >> SHIFT;

    always_comb begin
        win = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (idx == SEL_W'(w)) win = vec[w*SUM_W +: SUM_W];
        end
    end

endmodule

// File: rtl/hsum_top.sv
module hsum_top
    import hsum_pkg::*;
#(
    parameter int NUM_HARTS = 100,
    parameter int HARTSEL_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HARTS-1:0] halted,
    input  logic [HARTSEL_W-1:0] hartsel,
    input  logic                 rd_en,
    input  logic [1:0]           rd_addr,
    output logic                 rd_valid,
    output logic [31:0]          rd_data
);

    sum_word_t lvl_sum [NUM_LVLS];

    for (genvar k = 0; k < NUM_LVLS; k++) begin : gen_lvl
        localparam int GRP_LEN = ceil_div(NUM_HARTS, pow32(k));
        localparam int PAD     = ceil_div(GRP_LEN, SUM_W) * SUM_W;
        localparam bit IMPL    = (k == 0) || (NUM_HARTS > pow32(k));

        logic [PAD-1:0] grp;
        sum_word_t      win;

        if (k == 0) begin : gen_base
            always_comb begin
                grp = '0;
                grp[NUM_HARTS-1:0] = halted;
            end
        end else begin : gen_fold
            hsum_reduce #(
                .IN_W  (ceil_div(ceil_div(NUM_HARTS, pow32(k-1)), SUM_W) * SUM_W),
                .OUT_W (PAD)
            ) u_red (
                .in_bits  (gen_lvl[k-1].grp),
                .out_bits (grp)
            );
        end

        hsum_window #(
            .VEC_W (PAD),
            .SEL_W (HARTSEL_W),
            .SHIFT (LVL_SH*k + LVL_SH)
        ) u_win (
            .vec (grp),
            .sel (hartsel),
            .win (win)
        );

        assign lvl_sum[k] = IMPL ? win : '0;
    end

    rd_state_e state_q, state_d;
    sum_word_t data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     data_q <= '0;
        else if (rd_en) data_q <= lvl_sum[rd_addr];
    end

    assign rd_valid = (state_q == RD_RESP);
    assign rd_data  = data_q;

endmodule

// File: rtl/hsum_checker.sv
module hsum_checker #(
    parameter int NUM_HARTS = 100,
    parameter int HARTSEL_W = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [HARTSEL_W-1:0] hartsel,
    input logic                 rd_en,
    input logic [1:0]           rd_addr,
    input logic                 rd_valid,
    input logic [31:0]          rd_data
);

    localparam int LAST_WIN = (NUM_HARTS - 1) / 32;

    logic [HARTSEL_W-1:0] win0;
    assign win0 = hartsel >> 5;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && rd_data == 32'd0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r5_beyond_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 2'd0 && win0 > HARTSEL_W'(LAST_WIN)) |=> rd_data == 32'd0);

    a_r6_unbuilt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ((rd_addr == 2'd2 && NUM_HARTS <= 1024) ||
                   (rd_addr == 2'd3 && NUM_HARTS <= 32768))) |=> rd_data == 32'd0);

endmodule

bind hsum_top hsum_checker #(
    .NUM_HARTS (NUM_HARTS),
    .HARTSEL_W (HARTSEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hartsel  (hartsel),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/hsum_top_tb.sv
module hsum_top_tb;

    localparam int N  = 100;
    localparam int SW = 20;
    localparam int NV = 14;

    localparam int          V_HART [NV] = '{5, 5, 40, 40, 40, 99, 99, 99, 99, 70, 70, 70, 31, 32};
    localparam int          V_SEL  [NV] = '{0, 0, 0, 32, 0, 96, 0, 1024, 128, 0, 0, 71, 31, 0};
    localparam int          V_ADDR [NV] = '{0, 1, 0, 0, 1, 0, 1, 1, 0, 2, 3, 0, 0, 1};
    localparam logic [31:0] V_EXP  [NV] = '{32'h20, 32'h1, 32'h0, 32'h100, 32'h2, 32'h8,
                                            32'h8, 32'h0, 32'h0, 32'h0, 32'h0, 32'h40,
                                            32'h8000_0000, 32'h2};
    localparam string       V_REQ  [NV] = '{"R3", "R4", "R3", "R3", "R4", "R3", "R4", "R5",
                                            "R5", "R6", "R6", "R8", "R3", "R4"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  halted = '0;
    logic [SW-1:0] hartsel = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hsum_top #(.NUM_HARTS(N), .HARTSEL_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .halted(halted), .hartsel(hartsel),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input int addr, input int sel);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = 2'(addr);
        hartsel = SW'(sel);
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(rd_valid), 32'd0);
        check("R1 data", rd_data, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            halted = '0;
            halted[V_HART[v]] = 1'b1;
            do_read(V_ADDR[v], V_SEL[v]);
            check(V_REQ[v], rd_data, V_EXP[v]);
        end

        // R2: valid one cycle after request, then drops
        halted = '0;
        do_read(0, 0);
        check("R2 valid high", 32'(rd_valid), 32'd1);
        @(negedge clk);
        check("R2 valid low", 32'(rd_valid), 32'd0);

        // R5: all halted, last partial window
        halted = '1;
        do_read(0, 96);
        check("R5 partial window", rd_data, 32'h0000_000F);
        do_read(1, 0);
        check("R4 all groups", rd_data, 32'h0000_000F);
        do_read(2, 0);
        check("R6 level2 all halted", rd_data, 32'h0);
        do_read(0, 32'h1F);
        check("R8 low bits ignored", rd_data, 32'hFFFF_FFFF);

        // R7: data holds without a request
        halted = '0;
        halted[3] = 1'b1;
        do_read(0, 0);
        check("R7 captured", rd_data, 32'h8);
        halted = '0;
        halted[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 held", rd_data, 32'h8);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset data", rd_data, 32'd0);
        check("R1 reset valid", 32'(rd_valid), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule